// File: doc/BRIEF.md
# SMBus Register Target

This block sits on a two-wire SMBus segment as a target with a fixed 7-bit address and serves a small register file held inside it. SCL and SDA are brought in as plain inputs and oversampled with the system clock. A short synchronizer chain and edge detection find start, repeated start and stop conditions and SCL edges. SDA is only ever pulled low: the block drives an open-drain enable for its acknowledge bits and for the bits it returns on reads.

A write transaction carries a command byte first. That byte picks a register index and a block-mode flag, and it is kept until the next command arrives. Any data bytes that follow go to consecutive registers. Every start condition reloads the working pointer from the kept command, so a repeated start keeps the selection. A bare receive-byte read also returns the register named by the last command. Word transfers move the low byte first. In block mode the target puts a count byte in front of the data it returns. Each committed register write also appears on a one-cycle strobe with index and data for local logic.

Top module: `smb_reg_target`

## Requirements
- R1: After a start, the target compares the 7 address bits (sent MSB first) with its own address DEV_ADDR (default 0x2A). The eighth bit selects the direction, 1 meaning read. On a match it pulls SDA low for the whole ninth SCL period.
- R2: When the address does not match, the target never pulls SDA and raises no write strobe before the next start, whatever bytes the host then clocks.
- R3: In a write, the target acknowledges every byte after the address by pulling SDA low in its ninth SCL period.
- R4: The first byte after the address in a write is the command. Its low log2(NREG) bits give the register index and its bit 7 sets block mode. The command stays in force across transactions until another one is written.
- R5: Data bytes after the command are written to consecutive registers, starting at the selected index. For each one the target gives a one-cycle wr_stb_o pulse with wr_idx_o and wr_byte_o. A word write therefore places its low byte at the index and its high byte at index+1.
- R6: Every start or repeated start sets the read pointer back to the kept command index. A read after a repeated start, and a receive byte with no command, both return that register first.
- R7: Each data byte returned on a read advances the pointer by one, modulo NREG. Word and longer reads therefore walk consecutive registers and wrap from NREG-1 to 0. Writes wrap the same way.
- R8: In block mode, a read first returns a count byte equal to BLK_COUNT (default 4, at most 32) and then the data. In a block-mode write, the first byte after the command is the host's count: it is acknowledged but not stored.
- R9: After the host NACKs a returned byte, the target leaves SDA released until the next start, even if SCL keeps toggling.
- R10: A stop or start that arrives before the eighth bit of a byte ends the transfer. Nothing from that partial byte is written. A start begins a new address phase.
- R11: After reset, SDA is released, no strobe is raised, the command index is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb_o | output | 1 | One-cycle pulse for each committed register write |
| wr_idx_o | output | log2(NREG) | Register index of the committed write |
| wr_byte_o | output | 8 | Data byte of the committed write |

## Verification
The counter that tracks bit position is the most likely source of error, and a slip in it moves the acknowledge pull by a whole SCL period. The host then sees a missing ACK on the very byte where the slip occurs. A stale or misloaded pointer shows up only on the next read, as a wrong byte or a missing count prefix in block mode, so every write is followed later by a read-back of the same and neighbouring indices. Leaked drive after a NACK or after a foreign address corrupts bits the host clocks in afterwards, and the bench samples SDA during those extra clocks.

// File: rtl/smb_pkg.sv
package smb_pkg;
   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_ADDR = 2'd1,
      FR_WR   = 2'd2,
      FR_RD   = 2'd3
   } frame_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic prev_o
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 1) else $error("smb_line_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= line_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], line_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= 1'b1;
      else        prev_o <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
   parameter int NREG = 16,
   parameter int DW   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(NREG)-1:0]  waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(NREG)-1:0]  raddr,
   output logic [DW-1:0]            rdata
);
   localparam int AW = $clog2(NREG);

   logic [DW-1:0] cells [NREG];

   generate
      for (genvar gi = 0; gi < NREG; gi++) begin : g_cell
         logic [DW-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cell_q <= '0;
            else if (we && waddr == AW'(gi))    cell_q <= wdata;
         end
         assign cells[gi] = cell_q;
      end
   endgenerate

   assign rdata = cells[raddr];
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         NREG        = 16,
   parameter int         BLK_COUNT   = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_pull_o,
   output logic                    wr_stb_o,
   output logic [$clog2(NREG)-1:0] wr_idx_o,
   output logic [7:0]              wr_byte_o
);
   import smb_pkg::*;

   localparam int IDXW = $clog2(NREG);

   initial begin
      assert (NREG >= 2 && (NREG & (NREG - 1)) == 0)
         else $error("smb_reg_target: NREG must be a power of two");
      assert (IDXW <= 7)
         else $error("smb_reg_target: index must fit below the block-mode bit");
      assert (BLK_COUNT >= 1 && BLK_COUNT <= 32)
         else $error("smb_reg_target: BLK_COUNT out of range");
   end

   // bus line conditioning: index 0 = SCL, index 1 = SDA
   logic [1:0] line_raw, line_lvl, line_prv;
   assign line_raw = {sda_i, scl_i};

   generate
      for (genvar gl = 0; gl < 2; gl++) begin : g_sync
         smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_raw[gl]),
            .level_o (line_lvl[gl]),
            .prev_o  (line_prv[gl])
         );
      end
   endgenerate

   logic scl_rise, scl_fall, bus_start, bus_stop, sda_lvl;
   assign sda_lvl   = line_lvl[1];
   assign scl_rise  =  line_lvl[0] & ~line_prv[0];
   assign scl_fall  = ~line_lvl[0] &  line_prv[0];
   assign bus_start =  line_lvl[0] &  line_prv[0] &  line_prv[1] & ~line_lvl[1];
   assign bus_stop  =  line_lvl[0] &  line_prv[0] & ~line_prv[1] &  line_lvl[1];

   // protocol state
   frame_e          frame;
   logic [3:0]      bit_cnt;
   logic [6:0]      shreg;
   logic [7:0]      txreg;
   logic            is_read;
   logic            host_nack;
   logic [1:0]      byte_n;
   logic [IDXW-1:0] cmd_idx;
   logic            cmd_blk;
   logic [IDXW-1:0] cur_ptr;
   logic            cnt_pend;

   logic [7:0] new_byte, rd_q, tx_next;
   assign new_byte = {shreg, sda_lvl};
   assign tx_next  = cnt_pend ? 8'(BLK_COUNT) : rd_q;

   smb_regfile #(.NREG(NREG), .DW(8)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_stb_o),
      .waddr (wr_idx_o),
      .wdata (wr_byte_o),
      .raddr (cur_ptr),
      .rdata (rd_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame      <= FR_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         txreg      <= '0;
         is_read    <= 1'b0;
         host_nack  <= 1'b0;
         byte_n     <= '0;
         cmd_idx    <= '0;
         cmd_blk    <= 1'b0;
         cur_ptr    <= '0;
         cnt_pend   <= 1'b0;
         sda_pull_o <= 1'b0;
         wr_stb_o   <= 1'b0;
         wr_idx_o   <= '0;
         wr_byte_o  <= '0;
      end else begin
         wr_stb_o <= 1'b0;
         if (bus_start) begin
            frame      <= FR_ADDR;
            bit_cnt    <= '0;
            byte_n     <= '0;
            cur_ptr    <= cmd_idx;
            cnt_pend   <= cmd_blk;
            sda_pull_o <= 1'b0;
         end else if (bus_stop) begin
            frame      <= FR_IDLE;
            sda_pull_o <= 1'b0;
         end else if (frame != FR_IDLE) begin
            if (scl_rise) begin
               bit_cnt <= bit_cnt + 4'd1;
               if (bit_cnt < 4'd7) shreg <= new_byte[6:0];
               if (bit_cnt == 4'd7) begin
                  case (frame)
                     FR_ADDR: begin
                        if (shreg == DEV_ADDR) is_read <= sda_lvl;
                        else                   frame   <= FR_IDLE;
                     end
                     FR_WR: begin
                        if (byte_n == 2'd0) begin
                           cmd_idx  <= new_byte[IDXW-1:0];
                           cmd_blk  <= new_byte[7];
                           cur_ptr  <= new_byte[IDXW-1:0];
                           cnt_pend <= new_byte[7];
                        end else if (cnt_pend) begin
                           cnt_pend <= 1'b0;
                        end else begin
                           wr_stb_o  <= 1'b1;
                           wr_idx_o  <= cur_ptr;
                           wr_byte_o <= new_byte;
                           cur_ptr   <= cur_ptr + 1'b1;
                        end
                        if (byte_n != 2'd2) byte_n <= byte_n + 2'd1;
                     end
                     default: ;
                  endcase
               end
               if (bit_cnt == 4'd8 && frame == FR_RD) begin
                  host_nack <= sda_lvl;
                  if (cnt_pend) cnt_pend <= 1'b0;
                  else          cur_ptr  <= cur_ptr + 1'b1;
               end
            end else if (scl_fall) begin
               if (bit_cnt == 4'd8) begin
                  sda_pull_o <= (frame == FR_ADDR) || (frame == FR_WR);
               end else if (bit_cnt == 4'd9) begin
                  bit_cnt <= '0;
                  if (frame == FR_RD && host_nack) begin
                     frame      <= FR_IDLE;
                     sda_pull_o <= 1'b0;
                  end else if (frame == FR_RD || (frame == FR_ADDR && is_read)) begin
                     frame      <= FR_RD;
                     txreg      <= tx_next;
                     sda_pull_o <= ~tx_next[7];
                  end else begin
                     frame      <= FR_WR;
                     sda_pull_o <= 1'b0;
                  end
               end else if (frame == FR_RD) begin
                  sda_pull_o <= ~txreg[3'd7 - bit_cnt[2:0]];
               end else begin
                  sda_pull_o <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_pull,
   input logic          wr_stb,
   input logic          scl_fall,
   input logic          bus_start,
   input logic          bus_stop,
   input smb_pkg::frame_e frame,
   input logic [3:0]    bit_cnt
);
   import smb_pkg::*;

   // R9
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame == FR_IDLE |-> !sda_pull);

   // R5
   strobe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(frame) == FR_WR);

   // R5
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R1
   pull_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall || bus_start || bus_stop));

   // R10
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd9);

   // R10
   start_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (bit_cnt == 4'd0 && frame == FR_ADDR && !sda_pull));
endmodule

bind smb_reg_target smb_target_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_pull  (sda_pull_o),
   .wr_stb    (wr_stb_o),
   .scl_fall  (scl_fall),
   .bus_start (bus_start),
   .bus_stop  (bus_stop),
   .frame     (frame),
   .bit_cnt   (bit_cnt)
);

// File: tb/tb_smb_reg_target.sv
module tb_smb_reg_target;
   localparam int Q = 8;
   localparam logic [7:0] AW_BYTE = 8'h54;  // 0x2A, write
   localparam logic [7:0] AR_BYTE = 8'h55;  // 0x2A, read

   // kind: 0 write byte, 1 write word, 2 read byte, 3 read word, 4 receive byte
   localparam logic [31:0] VEC [7] = '{
      {8'd0, 8'h03, 8'h5A, 8'h00},
      {8'd1, 8'h05, 8'h11, 8'h22},
      {8'd2, 8'h03, 8'h5A, 8'h00},
      {8'd3, 8'h05, 8'h11, 8'h22},
      {8'd4, 8'h00, 8'h11, 8'h00},
      {8'd1, 8'h0F, 8'h77, 8'h88},
      {8'd3, 8'h0F, 8'h77, 8'h88}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_pull = 1'b0;
   logic sda_pull, wr_stb;
   logic [3:0] wr_idx;
   logic [7:0] wr_byte;
   wire sda_bus = !(host_pull || sda_pull);

   always #10 clk = ~clk;

   smb_reg_target dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .sda_pull_o (sda_pull),
      .wr_stb_o   (wr_stb),
      .wr_idx_o   (wr_idx),
      .wr_byte_o  (wr_byte)
   );

   int checks = 0;
   int fails = 0;
   int n_stb = 0;
   logic [3:0] last_idx = '0;
   logic [7:0] last_dat = '0;
   logic pull_seen = 1'b0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         n_stb++;
         last_idx = wr_idx;
         last_dat = wr_byte;
      end
      if (sda_pull) pull_seen = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      host_pull = 1'b0; tick(Q);
      scl = 1'b1;       tick(Q);
      host_pull = 1'b1; tick(Q);
      scl = 1'b0;       tick(Q);
   endtask

   task automatic bus_stop();
      host_pull = 1'b1; tick(Q);
      scl = 1'b1;       tick(Q);
      host_pull = 1'b0; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         host_pull = !b[i]; tick(Q);
         scl = 1'b1;        tick(Q);
         scl = 1'b0;        tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      host_pull = 1'b0; tick(Q);
      scl = 1'b1;       tick(Q/2);
      acked = !sda_bus; tick(Q/2);
      scl = 1'b0;       tick(Q);
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      host_pull = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q/2);
         b[i] = sda_bus; tick(Q/2);
         scl = 1'b0;
      end
      tick(Q/2);
      host_pull = !nack; tick(Q);
      scl = 1'b1;        tick(Q);
      scl = 1'b0;        tick(Q/2);
      host_pull = 1'b0;  tick(Q/2);
   endtask

   // addressed write: command then n data bytes
   task automatic write_txn(input logic [7:0] cmd, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
      bit a;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      bus_start();
      send_byte(AW_BYTE, a); chk(a, "R1 address ack", a, 1);
      send_byte(cmd, a);     chk(a, "R3 command ack", a, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], a); chk(a, "R3 data ack", a, 1);
      end
      bus_stop();
   endtask

   // command, repeated start, read n bytes (NACK on last)
   task automatic read_txn(input logic [7:0] cmd, input int n, output logic [39:0] got);
      bit a;
      logic [7:0] b;
      got = '0;
      bus_start();
      send_byte(AW_BYTE, a); chk(a, "R1 address ack", a, 1);
      send_byte(cmd, a);     chk(a, "R3 command ack", a, 1);
      bus_start();
      send_byte(AR_BYTE, a); chk(a, "R6 read address ack after repeated start", a, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k == n - 1, b);
         got[8*k +: 8] = b;
      end
      bus_stop();
   endtask

   task automatic recv_txn(output logic [7:0] b);
      bit a;
      bus_start();
      send_byte(AR_BYTE, a); chk(a, "R1 read address ack", a, 1);
      recv_byte(1'b1, b);
      bus_stop();
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      logic [39:0] got;
      logic [7:0] b;
      bit a;
      int s0;

      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R11 reset state
      chk(sda_pull == 1'b0, "R11 sda released", sda_pull, 0);
      chk(wr_stb == 1'b0, "R11 no strobe", wr_stb, 0);
      recv_txn(b);
      chk(b == 8'h00, "R11 register 0 after reset", b, 0);

      // table of transactions
      for (int v = 0; v < 7; v++) begin
         logic [7:0] kind, cmd, lo, hi;
         {kind, cmd, lo, hi} = VEC[v];
         s0 = n_stb;
         case (kind)
            8'd0: begin
               write_txn(cmd, 1, lo, 8'h00, 8'h00);
               chk(n_stb - s0 == 1, "R5 one strobe for byte write", n_stb - s0, 1);
               chk(last_idx == cmd[3:0] && last_dat == lo, "R4 R5 strobe index/data",
                   {last_idx, last_dat}, {cmd[3:0], lo});
            end
            8'd1: begin
               write_txn(cmd, 2, lo, hi, 8'h00);
               chk(n_stb - s0 == 2, "R5 two strobes for word write", n_stb - s0, 2);
               chk(last_idx == cmd[3:0] + 4'd1 && last_dat == hi, "R7 high byte at next index",
                   {last_idx, last_dat}, {cmd[3:0] + 4'd1, hi});
            end
            8'd2: begin
               read_txn(cmd, 1, got);
               chk(got[7:0] == lo, "R6 read byte", got[7:0], lo);
            end
            8'd3: begin
               read_txn(cmd, 2, got);
               chk(got[7:0] == lo, "R7 read word low byte", got[7:0], lo);
               chk(got[15:8] == hi, "R7 read word high byte", got[15:8], hi);
            end
            default: begin
               recv_txn(b);
               chk(b == lo, "R6 receive byte uses last command", b, lo);
            end
         endcase
      end

      // R8 block write: count byte not stored
      s0 = n_stb;
      write_txn(8'h82, 3, 8'h02, 8'hA1, 8'hA2);
      chk(n_stb - s0 == 2, "R8 block write skips count", n_stb - s0, 2);
      chk(last_idx == 4'd3 && last_dat == 8'hA2, "R8 block write last data",
          {last_idx, last_dat}, {4'd3, 8'hA2});
      // R8 block read: count then data
      read_txn(8'h82, 5, got);
      chk(got[7:0] == 8'h04, "R8 block read count", got[7:0], 8'h04);
      chk(got[15:8] == 8'hA1, "R8 block data 0", got[15:8], 8'hA1);
      chk(got[23:16] == 8'hA2, "R8 block data 1", got[23:16], 8'hA2);
      chk(got[39:32] == 8'h11, "R8 R7 block data 3", got[39:32], 8'h11);

      // R2 foreign address ignored
      s0 = n_stb;
      bus_start();
      pull_seen = 1'b0;
      send_byte(8'h56, a); chk(!a, "R2 no ack on foreign address", a, 0);
      send_byte(8'h03, a); chk(!a, "R2 no ack on following byte", a, 0);
      send_byte(8'h00, a);
      bus_stop();
      chk(!pull_seen, "R2 SDA never pulled", pull_seen, 0);
      chk(n_stb == s0, "R2 no strobe", n_stb - s0, 0);
      read_txn(8'h03, 1, got);
      chk(got[7:0] == 8'hA2, "R2 register untouched", got[7:0], 8'hA2);

      // R9 release after NACK
      bus_start();
      send_byte(AW_BYTE, a);
      send_byte(8'h05, a);
      bus_start();
      send_byte(AR_BYTE, a);
      recv_byte(1'b1, b);
      chk(b == 8'h11, "R9 byte before NACK", b, 8'h11);
      pull_seen = 1'b0;
      recv_byte(1'b1, b);
      chk(b == 8'hFF && !pull_seen, "R9 SDA released after NACK", b, 8'hFF);
      bus_stop();

      // R10 stop in the middle of a data byte
      s0 = n_stb;
      bus_start();
      send_byte(AW_BYTE, a);
      send_byte(8'h07, a);
      send_bits(8'hC3, 4);
      bus_stop();
      chk(n_stb == s0, "R10 partial byte not written", n_stb - s0, 0);
      recv_txn(b);
      chk(b == 8'h00, "R10 register 7 unchanged", b, 0);

      // R10 start in the middle of the address
      bus_start();
      send_bits(AW_BYTE, 3);
      bus_start();
      send_byte(AR_BYTE, a);
      chk(a, "R10 new address after mid-byte start", a, 1);
      recv_byte(1'b1, b);
      bus_stop();
      chk(b == 8'h00, "R10 read after restart", b, 0);

      // R10 committed byte kept, trailing partial byte dropped
      s0 = n_stb;
      bus_start();
      send_byte(AW_BYTE, a);
      send_byte(8'h08, a);
      send_byte(8'h3C, a);
      send_bits(8'hFF, 5);
      bus_stop();
      chk(n_stb - s0 == 1, "R10 only full byte committed", n_stb - s0, 1);
      read_txn(8'h08, 2, got);
      chk(got[15:0] == 16'h003C, "R10 word readback", got[15:0], 16'h003C);

      done = 1'b1;
      finish_run();
   end
endmodule